// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences a device between four operating modes: run, sleep, stop and standby. Software selects a target mode with a 2-bit request and an entry strobe. A single wake line brings the device back. Each deeper mode turns off more of the device. Sleep gates only the CPU clock. Stop also gates the peripheral clocks and shuts down the PLL and the crystal, but keeps SRAM contents. Standby additionally drops SRAM retention.

The way the device wakes depends on the mode it is leaving. Sleep returns straight to run. Stop returns to run with the clock source forced to the internal RC, so software must set the clock tree up again. Standby wakes through a fixed-length reset pulse and leaves a status bit set for the restarted firmware. Entry into stop or standby takes one step per cycle: clocks, then PLL, then crystal. A wake event during these steps cancels the entry. A run request strobed while already in run tells the block that the clocks have been set up again, and releases the RC selection.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, curMode reads 0 (run) and all of the following hold: cpuClkEn=1, perClkEn=1, pllDisable=0, xtalDisable=0, sramRetain=1, wakeReset=0, standbyWake=0 and clkSrcRc=1.
- R2: In run, an entry strobe with modeReq=1 and wakeEvt low has this effect from the next cycle: curMode=1, cpuClkEn=0, perClkEn=1, pllDisable=0 and xtalDisable=0. A wake event in sleep gives curMode=0 and cpuClkEn=1 on the next cycle, and clkSrcRc is left unchanged.
- R3: In run, an entry strobe with modeReq=2 (stop) or modeReq=3 (standby) starts the entry steps. In the first cycle after the strobe, cpuClkEn=0 and perClkEn=0. In the second, pllDisable=1 is added. In the third, xtalDisable=1 is added. In the fourth, curMode shows the target. curMode stays 0 during the three step cycles.
- R4: In stop, sramRetain=1. A wake event in stop has this effect on the next cycle: curMode=0, both clock enables at 1, pllDisable=0, xtalDisable=0 and clkSrcRc=1.
- R5: In standby, sramRetain=0. A wake event in standby sets wakeReset=1 for exactly RST_CYCLES cycles, starting the next cycle. In that same cycle standbyWake becomes 1. curMode stays 3 while the pulse is high. In the cycle after the pulse, curMode=0, both clock enables are 1, the PLL and crystal are enabled, sramRetain=1 and clkSrcRc=1.
- R6: A wake event during any entry step cancels the entry. On the next cycle: curMode=0, both clock enables at 1, pllDisable=0, xtalDisable=0, sramRetain=1, and standbyWake is not set. clkSrcRc becomes 1 if pllDisable was already 1 when the wake arrived; otherwise it is unchanged.
- R7: In run, an entry strobe with modeReq=0 and wakeEvt low sets clkSrcRc=0 on the next cycle, and curMode stays 0.
- R8: An entry strobe is ignored in every state except run. It is also ignored in run when wakeEvt is high in the same cycle.
- R9: Any entry strobe accepted in run clears standbyWake on the next cycle.
- R10: A wake event in run, with no strobe, changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeReq | input | 2 | Requested mode: 0 run, 1 sleep, 2 stop, 3 standby |
| enterStb | input | 1 | One-cycle strobe that applies modeReq |
| wakeEvt | input | 1 | Wake event line |
| cpuClkEn | output | 1 | CPU clock gate enable |
| perClkEn | output | 1 | Peripheral clock gate enable |
| pllDisable | output | 1 | PLL shutdown |
| xtalDisable | output | 1 | Crystal oscillator shutdown |
| sramRetain | output | 1 | SRAM retention enable |
| wakeReset | output | 1 | Reset pulse issued on wake from standby |
| clkSrcRc | output | 1 | System clock source: 1 internal RC, 0 PLL |
| curMode | output | 2 | Current mode, same encoding as modeReq |
| standbyWake | output | 1 | Set when the last wake came from standby |

## Verification
The assertions check these properties on every cycle: the sleep gating pattern, retention held in stop and dropped in standby, the RC selection on wake from stop, PLL shutdown only after the clocks are gated, crystal shutdown only after the PLL, and a reset pulse only out of standby. Some properties can only be shown by the bench scenarios. These are the exact cycle of each entry step, the exact length of the reset pulse, and the cancel behaviour at each step. The same applies to strobes that must be ignored in sleep or when they collide with a wake, the release of the RC selection, and clearing of the status bit.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN     = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_STOP    = 2'd2,
    MODE_STANDBY = 2'd3
  } pwrMode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_GATE,
    ST_PLLOFF,
    ST_XTALOFF,
    ST_STOP,
    ST_STANDBY,
    ST_RSTPULSE
  } ctlState_e;

  typedef struct packed {
    logic gateCpu;
    logic gatePer;
    logic pllOff;
    logic xtalOff;
    logic dropRetain;
    logic restoreAll;
    logic forceRc;
    logic selectPll;
    logic startPulse;
    logic clearFlag;
  } ctlStrobes_t;
endpackage

// File: rtl/pmc_control.sv
module pmc_control
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeReq,
  input  logic              enterStb,
  input  logic              wakeEvt,
  input  logic              pulseDone,
  output ctlStrobes_t       stb,
  output pwrMode_e          curMode
);
  ctlState_e state, stateNext;
  logic      tgtStandby, tgtStandbyNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RUN;
      tgtStandby <= 1'b0;
    end else begin
      state      <= stateNext;
      tgtStandby <= tgtStandbyNext;
    end
  end

  always_comb begin
    stateNext      = state;
    tgtStandbyNext = tgtStandby;
    stb            = '0;
    unique case (state)
      ST_RUN: begin
        if (enterStb && !wakeEvt) begin
          stb.clearFlag = 1'b1;
          unique case (pwrMode_e'(modeReq))
            MODE_RUN:   stb.selectPll = 1'b1;
            MODE_SLEEP: begin
              stb.gateCpu = 1'b1;
              stateNext   = ST_SLEEP;
            end
            default: begin
              stb.gateCpu    = 1'b1;
              stb.gatePer    = 1'b1;
              stateNext      = ST_GATE;
              tgtStandbyNext = (modeReq == MODE_STANDBY);
            end
          endcase
        end
      end
      ST_SLEEP: begin
        if (wakeEvt) begin
          stb.restoreAll = 1'b1;
          stateNext      = ST_RUN;
        end
      end
      ST_GATE: begin
        if (wakeEvt) begin
          stb.restoreAll = 1'b1;
          stateNext      = ST_RUN;
        end else begin
          stb.pllOff = 1'b1;
          stateNext  = ST_PLLOFF;
        end
      end
      ST_PLLOFF: begin
        if (wakeEvt) begin
          stb.restoreAll = 1'b1;
          stb.forceRc    = 1'b1;
          stateNext      = ST_RUN;
        end else begin
          stb.xtalOff = 1'b1;
          stateNext   = ST_XTALOFF;
        end
      end
      ST_XTALOFF: begin
        if (wakeEvt) begin
          stb.restoreAll = 1'b1;
          stb.forceRc    = 1'b1;
          stateNext      = ST_RUN;
        end else if (tgtStandby) begin
          stb.dropRetain = 1'b1;
          stateNext      = ST_STANDBY;
        end else begin
          stateNext = ST_STOP;
        end
      end
      ST_STOP: begin
        if (wakeEvt) begin
          stb.restoreAll = 1'b1;
          stb.forceRc    = 1'b1;
          stateNext      = ST_RUN;
        end
      end
      ST_STANDBY: begin
        if (wakeEvt) begin
          stb.startPulse = 1'b1;
          stateNext      = ST_RSTPULSE;
        end
      end
      ST_RSTPULSE: begin
        if (pulseDone) begin
          stb.restoreAll = 1'b1;
          stb.forceRc    = 1'b1;
          stateNext      = ST_RUN;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_SLEEP:                curMode = MODE_SLEEP;
      ST_STOP:                 curMode = MODE_STOP;
      ST_STANDBY, ST_RSTPULSE: curMode = MODE_STANDBY;
      default:                 curMode = MODE_RUN;
    endcase
  end

  AST_ENTRY_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.gatePer && !stb.restoreAll) |=> (curMode == MODE_RUN)); // R3
endmodule

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t stb,
  output logic        pulseDone,
  output logic        cpuClkEn,
  output logic        perClkEn,
  output logic        pllDis,
  output logic        xtalDis,
  output logic        retain,
  output logic        rcSel,
  output logic        wakeRst,
  output logic        sbyFlag
);
  localparam int CNT_W = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign pulseDone = wakeRst && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuClkEn <= 1'b1;
      perClkEn <= 1'b1;
      pllDis   <= 1'b0;
      xtalDis  <= 1'b0;
      retain   <= 1'b1;
      wakeRst  <= 1'b0;
    end else if (stb.restoreAll) begin
      cpuClkEn <= 1'b1;
      perClkEn <= 1'b1;
      pllDis   <= 1'b0;
      xtalDis  <= 1'b0;
      retain   <= 1'b1;
      wakeRst  <= 1'b0;
    end else begin
      if (stb.gateCpu)    cpuClkEn <= 1'b0;
      if (stb.gatePer)    perClkEn <= 1'b0;
      if (stb.pllOff)     pllDis   <= 1'b1;
      if (stb.xtalOff)    xtalDis  <= 1'b1;
      if (stb.dropRetain) retain   <= 1'b0;
      if (stb.startPulse) wakeRst  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt <= '0;
    else if (stb.startPulse)     cnt <= CNT_LOAD;
    else if (wakeRst && cnt != '0) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rcSel <= 1'b1;
    else if (stb.forceRc)   rcSel <= 1'b1;
    else if (stb.selectPll) rcSel <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sbyFlag <= 1'b0;
    else if (stb.startPulse) sbyFlag <= 1'b1;
    else if (stb.clearFlag)  sbyFlag <= 1'b0;
  end

  AST_PLL_AFTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllDis) |-> (!$past(cpuClkEn) && !$past(perClkEn))); // R3
  AST_XTAL_AFTER_PLL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xtalDis) |-> $past(pllDis)); // R3
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeRst) |-> sbyFlag); // R5
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeReq,
  input  logic              enterStb,
  input  logic              wakeEvt,
  output logic              cpuClkEn,
  output logic              perClkEn,
  output logic              pllDisable,
  output logic              xtalDisable,
  output logic              sramRetain,
  output logic              wakeReset,
  output logic              clkSrcRc,
  output logic [MODE_W-1:0] curMode,
  output logic              standbyWake
);
  ctlStrobes_t stb;
  pwrMode_e    modeNow;
  logic        pulseDone;

  pmc_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .modeReq  (modeReq),
    .enterStb (enterStb),
    .wakeEvt  (wakeEvt),
    .pulseDone(pulseDone),
    .stb      (stb),
    .curMode  (modeNow)
  );

  pmc_datapath #(.RST_CYCLES(RST_CYCLES)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pulseDone(pulseDone),
    .cpuClkEn (cpuClkEn),
    .perClkEn (perClkEn),
    .pllDis   (pllDisable),
    .xtalDis  (xtalDisable),
    .retain   (sramRetain),
    .rcSel    (clkSrcRc),
    .wakeRst  (wakeReset),
    .sbyFlag  (standbyWake)
  );

  assign curMode = modeNow;

  AST_SLEEP_GATING: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_SLEEP) |-> (!cpuClkEn && perClkEn && !pllDisable)); // R2
  AST_STOP_RETAIN: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_STOP) |-> (sramRetain && pllDisable && xtalDisable && !perClkEn)); // R4
  AST_STOP_WAKE_RC: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_STOP && wakeEvt) |=> (clkSrcRc && curMode == MODE_RUN)); // R4
  AST_SBY_NO_RETAIN: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_STANDBY) |-> !sramRetain); // R5
  AST_PULSE_FROM_SBY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReset) |-> ($past(curMode) == MODE_STANDBY)); // R5
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int RST_CYCLES = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeReq = 2'd0;
  logic       enterStb = 1'b0;
  logic       wakeEvt = 1'b0;
  logic       cpuClkEn, perClkEn, pllDisable, xtalDisable, sramRetain;
  logic       wakeReset, clkSrcRc, standbyWake;
  logic [1:0] curMode;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.RST_CYCLES(RST_CYCLES)) i_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .enterStb(enterStb),
    .wakeEvt(wakeEvt), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn),
    .pllDisable(pllDisable), .xtalDisable(xtalDisable), .sramRetain(sramRetain),
    .wakeReset(wakeReset), .clkSrcRc(clkSrcRc), .curMode(curMode),
    .standbyWake(standbyWake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // packed outputs: {cpu, per, pll, xtal, retain, wakeRst, rc, sbyWake, mode[1:0]}
  function automatic int outs();
    return {cpuClkEn, perClkEn, pllDisable, xtalDisable, sramRetain,
            wakeReset, clkSrcRc, standbyWake, curMode};
  endfunction

  task automatic strobe(input logic [1:0] m);
    @(negedge clk);
    modeReq = m; enterStb = 1'b1;
    @(negedge clk);
    enterStb = 1'b0;
  endtask

  task automatic wake();
    @(negedge clk);
    wakeEvt = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", curMode, 0);
    chk("R1 outputs", outs(), 10'b11_0010_1000);
  endtask

  task automatic t_release();
    strobe(2'd0);
    chk("R7 rc released", clkSrcRc, 0);
    chk("R7 mode run", curMode, 0);
  endtask

  task automatic t_sleep();
    strobe(2'd1);
    chk("R2 sleep mode", curMode, 1);
    chk("R2 sleep gating", {cpuClkEn, perClkEn, pllDisable, xtalDisable}, 4'b0100);
    strobe(2'd2);
    repeat (3) @(negedge clk);
    chk("R8 strobe ignored in sleep", outs(), 10'b01_0010_0001);
    wake();
    chk("R2 wake to run", curMode, 0);
    chk("R2 cpu clock back", cpuClkEn, 1);
    chk("R2 rc unchanged", clkSrcRc, 0);
  endtask

  task automatic t_stop();
    strobe(2'd2);
    chk("R3 step1", {cpuClkEn, perClkEn, pllDisable, xtalDisable, curMode}, 6'b000000);
    @(negedge clk);
    chk("R3 step2", {pllDisable, xtalDisable, curMode}, 4'b1000);
    @(negedge clk);
    chk("R3 step3", {pllDisable, xtalDisable, curMode}, 4'b1100);
    @(negedge clk);
    chk("R3 stop reached", curMode, 2);
    chk("R4 stop retain", sramRetain, 1);
    repeat (3) @(negedge clk);
    wake();
    chk("R4 stop wake", outs(), 10'b11_0010_1000);
  endtask

  task automatic t_wake_in_run();
    t_release();
    wake();
    chk("R10 wake in run", outs(), 10'b11_0010_0000);
  endtask

  task automatic t_collide();
    @(negedge clk);
    modeReq = 2'd1; enterStb = 1'b1; wakeEvt = 1'b1;
    @(negedge clk);
    enterStb = 1'b0; wakeEvt = 1'b0;
    chk("R8 strobe with wake ignored", outs(), 10'b11_0010_0000);
  endtask

  task automatic t_standby();
    strobe(2'd3);
    repeat (3) @(negedge clk);
    chk("R5 standby mode", curMode, 3);
    chk("R5 retain dropped", sramRetain, 0);
    wake();
    for (int i = 0; i < RST_CYCLES; i++) begin
      chk("R5 pulse high", wakeReset, 1);
      chk("R5 mode during pulse", curMode, 3);
      @(negedge clk);
    end
    chk("R5 after pulse", outs(), 10'b11_0010_1100);
  endtask

  task automatic t_flag_clear();
    chk("R9 flag before", standbyWake, 1);
    strobe(2'd0);
    chk("R9 flag cleared", standbyWake, 0);
  endtask

  task automatic t_cancel_early();
    @(negedge clk);
    modeReq = 2'd2; enterStb = 1'b1;
    @(negedge clk);
    enterStb = 1'b0; wakeEvt = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
    chk("R6 early cancel", outs(), 10'b11_0010_0000);
    repeat (4) @(negedge clk);
    chk("R6 stays run", curMode, 0);
  endtask

  task automatic t_cancel_late();
    strobe(2'd3);
    @(negedge clk);
    wakeEvt = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
    chk("R6 late cancel", outs(), 10'b11_0010_1000);
    repeat (4) @(negedge clk);
    chk("R6 no standby", curMode, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_release();
    t_sleep();
    t_stop();
    t_wake_in_run();
    t_collide();
    t_standby();
    t_flag_clear();
    t_cancel_early();
    t_cancel_late();
    finish_run();
  end
endmodule